// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Decoder with Selectable Parity Sense

This block takes a 31-bit Hamming codeword and returns the 25 information bits it carries. It forms a 5-bit syndrome from the received word, using either the even or the odd parity convention. The convention comes from a configuration input that must agree with the sender. A nonzero syndrome names the one position that was flipped. That position is inverted before the information bits are pulled out.

Each output word comes with three status fields: a flag saying a correction was made, the corrected position, and a flag raised when the parity-sense bit inside the codeword disagrees with the configured sense. The block has one register stage with valid/ready flow control on both sides, so a word accepted on one clock edge is presented on the next. It is meant to sit on a receive path. It does not handle words with two or more flipped bits reliably.

Top module: `hamdec_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is low after that edge, and `in_ready` is high once reset has cleared the output stage.
- R2: Codeword positions are numbered 1 to 31, and position p travels on `in_cw[p-1]`. Positions 1, 2, 4, 8 and 16 hold check bits and position 3 holds the parity-sense bit (1 = odd, 0 = even). The remaining 25 positions carry data in ascending order, so position 5 goes to `out_data[0]` and position 31 to `out_data[24]`. In even sense (`cfg_odd` = 0), syndrome bit k is the XOR of all positions whose index has bit k set. An error-free word gives `out_err` = 0, `out_pos` = 0 and the original data.
- R3: In odd sense (`cfg_odd` = 1), each syndrome bit is inverted. A word encoded so that every check group has odd parity decodes with `out_err` = 0, `out_pos` = 0 and the original data.
- R4: A single flipped data position p is restored in `out_data`, with `out_err` = 1 and `out_pos` = p.
- R5: A single flipped check position (1, 2, 4, 8 or 16) leaves `out_data` intact, with `out_err` = 1 and `out_pos` naming that position.
- R6: A flipped parity-sense bit (position 3) is corrected before it is compared, so `out_mismatch` stays 0, `out_err` = 1 and `out_pos` = 3.
- R7: `out_mismatch` is 1 exactly when the corrected position-3 bit differs from `cfg_odd`.
- R8: A word accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that same edge.
- R9: While `out_valid` is high and `out_ready` is low, the output word and all its flags hold steady.
- R10: `in_ready` is low while an output word is stalled. When `in_valid` is low and the output is drained, no word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_odd | input | 1 | Configured parity sense: 1 odd, 0 even |
| in_valid | input | 1 | Codeword present |
| in_ready | output | 1 | Decoder can take a codeword |
| in_cw | input | 31 | Received codeword, position p on bit p-1 |
| out_valid | output | 1 | Decoded word present |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_data | output | 25 | Recovered information bits |
| out_err | output | 1 | A single-bit correction was applied |
| out_pos | output | 5 | Corrected position, 0 when none |
| out_mismatch | output | 1 | Embedded parity-sense bit differs from cfg_odd |

## Verification
The properties assume that reset is applied before traffic starts and that the consumer may drop `out_ready` for any number of cycles. They also assume that `cfg_odd` and `in_cw` are only meaningful in the cycle a word is accepted. The stimulus keeps to this: the driver holds the codeword and sense steady from the moment it raises `in_valid` until the handshake completes, and the ready pattern on the output side comes from a pseudo-random sequence that includes long stalls. Every codeword the bench sends has at most one flipped position, because the block makes no promise for heavier damage.

// File: rtl/hamdec_pkg.sv
package hamdec_pkg;

   typedef enum logic {
      SENSE_EVEN = 1'b0,
      SENSE_ODD  = 1'b1
   } sense_e;

   // true for positions that carry a check bit
   function automatic bit is_check_pos(int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // true for positions that hold no information bit
   function automatic bit is_reserved_pos(int p, int mode_pos);
      return is_check_pos(p) || (p == mode_pos);
   endfunction

   // rank of position p among the information positions, counted from 0
   function automatic int info_index(int p, int mode_pos);
      int n;
      n = 0;
      for (int q = 1; q < p; q++) begin
         if (!is_reserved_pos(q, mode_pos)) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/hamdec_syndrome.sv
module hamdec_syndrome #(
   parameter int SYN_W = 5,
   localparam int CODE_W = (1 << SYN_W) - 1
) (
   input  logic [CODE_W-1:0] cw_i,
   input  logic              odd_i,
   output logic [SYN_W-1:0]  syn_o
);

   for (genvar k = 0; k < SYN_W; k++) begin : g_bit
      logic grp;
      always_comb begin
         grp = 1'b0;
         for (int p = 1; p <= CODE_W; p++) begin
            if (((p >> k) & 1) != 0) grp ^= cw_i[p-1];
         end
      end
      // odd sense: a healthy group XORs to one, so flip it
      assign syn_o[k] = grp ^ odd_i;
   end

endmodule

// File: rtl/hamdec_fix_extract.sv
module hamdec_fix_extract #(
   parameter int SYN_W    = 5,
   parameter int MODE_POS = 3,
   localparam int CODE_W  = (1 << SYN_W) - 1,
   localparam int DATA_W  = CODE_W - SYN_W - 1
) (
   input  logic [CODE_W-1:0] cw_i,
   input  logic [SYN_W-1:0]  syn_i,
   output logic [DATA_W-1:0] data_o,
   output logic              mode_o
);

   // Only positions that reach an output get a correction gate.
   // Check positions are consumed by the syndrome and need none.
   for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
      if (p == MODE_POS) begin : g_mode
         assign mode_o = cw_i[p-1] ^ (syn_i == SYN_W'(p));
      end else if (!hamdec_pkg::is_check_pos(p)) begin : g_info
         localparam int IDX = hamdec_pkg::info_index(p, MODE_POS);
         assign data_o[IDX] = cw_i[p-1] ^ (syn_i == SYN_W'(p));
      end
   end

endmodule

// File: rtl/hamdec_outreg.sv
module hamdec_outreg #(
   parameter int PAY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PAY_W-1:0] in_pay,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [PAY_W-1:0] out_pay
);

   logic             full_q;
   logic [PAY_W-1:0] pay_q;

   assign in_ready  = !full_q || out_ready;
   assign out_valid = full_q;
   assign out_pay   = pay_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
      end else if (in_ready) begin
         full_q <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid && in_ready) pay_q <= in_pay;
   end

endmodule

// File: rtl/hamdec_top.sv
module hamdec_top #(
   parameter int SYN_W    = 5,
   parameter int MODE_POS = 3,
   localparam int CODE_W  = (1 << SYN_W) - 1,
   localparam int DATA_W  = CODE_W - SYN_W - 1,
   localparam int PAY_W   = DATA_W + SYN_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_odd,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CODE_W-1:0] in_cw,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_err,
   output logic [SYN_W-1:0]  out_pos,
   output logic              out_mismatch
);

   if (SYN_W < 3 || SYN_W > 6) begin : g_bad_syn
      $error("hamdec_top: SYN_W must lie in 3..6");
   end
   if (MODE_POS < 3 || MODE_POS > CODE_W || hamdec_pkg::is_check_pos(MODE_POS)) begin : g_bad_mode
      $error("hamdec_top: MODE_POS must be a non-check position inside the codeword");
   end

   hamdec_pkg::sense_e sense;
   assign sense = hamdec_pkg::sense_e'(cfg_odd);

   logic [SYN_W-1:0]  syn;
   logic [DATA_W-1:0] data_fix;
   logic              mode_fix;
   logic              mism;
   logic [PAY_W-1:0]  pay_in;
   logic [PAY_W-1:0]  pay_out;

   hamdec_syndrome #(.SYN_W(SYN_W)) u_syn (
      .cw_i  (in_cw),
      .odd_i (sense == hamdec_pkg::SENSE_ODD),
      .syn_o (syn)
   );

   hamdec_fix_extract #(.SYN_W(SYN_W), .MODE_POS(MODE_POS)) u_fix (
      .cw_i   (in_cw),
      .syn_i  (syn),
      .data_o (data_fix),
      .mode_o (mode_fix)
   );

   assign mism   = mode_fix ^ cfg_odd;
   assign pay_in = {mism, (syn != '0), syn, data_fix};

   hamdec_outreg #(.PAY_W(PAY_W)) u_out (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_pay    (pay_in),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_pay   (pay_out)
   );

   assign out_data     = pay_out[DATA_W-1:0];
   assign out_pos      = pay_out[DATA_W +: SYN_W];
   assign out_err      = pay_out[DATA_W+SYN_W];
   assign out_mismatch = pay_out[PAY_W-1];

endmodule

// File: rtl/hamdec_checker.sv
module hamdec_checker #(
   parameter int SYN_W    = 5,
   localparam int CODE_W  = (1 << SYN_W) - 1,
   localparam int DATA_W  = CODE_W - SYN_W - 1
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_err,
   input logic [SYN_W-1:0]  out_pos,
   input logic              out_mismatch
);

   assert_reset_R1: assert property (@(posedge clk) rst |=> !out_valid);

   assert_clean_pos_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_err |-> out_pos == '0);

   assert_err_pos_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_err |-> out_pos != '0);

   assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err)
                                  && $stable(out_pos) && $stable(out_mismatch));

   assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);

   assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid && out_ready |=> !out_valid);

endmodule

bind hamdec_top hamdec_checker #(.SYN_W(SYN_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_data     (out_data),
   .out_err      (out_err),
   .out_pos      (out_pos),
   .out_mismatch (out_mismatch)
);

// File: tb/tb_hamdec_top.sv
`timescale 1ns/100ps
module tb_hamdec_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_odd = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [30:0] in_cw = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [24:0] out_data;
   logic        out_err;
   logic [4:0]  out_pos;
   logic        out_mismatch;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit run_rdy = 1'b0;

   typedef struct {
      logic [24:0] d;
      logic        e;
      logic [4:0]  p;
      logic        mm;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   hamdec_top dut (
      .clk(clk), .rst(rst), .cfg_odd(cfg_odd),
      .in_valid(in_valid), .in_ready(in_ready), .in_cw(in_cw),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_err(out_err), .out_pos(out_pos), .out_mismatch(out_mismatch)
   );

   function automatic bit reserved(int p);
      return p == 1 || p == 2 || p == 3 || p == 4 || p == 8 || p == 16;
   endfunction

   // builds a word whose check groups XOR to 'odd', with a chosen sense bit
   function automatic logic [30:0] encode(logic [24:0] d, bit odd, bit sense_bit);
      logic [30:0] w;
      int n;
      w = '0;
      n = 0;
      for (int p = 1; p <= 31; p++) begin
         if (!reserved(p)) begin
            w[p-1] = d[n];
            n++;
         end
      end
      w[2] = sense_bit;
      for (int k = 0; k < 5; k++) begin
         logic par;
         par = odd;
         for (int p = 1; p <= 31; p++) begin
            if (((p >> k) & 1) != 0 && p != (1 << k)) par ^= w[p-1];
         end
         w[(1 << k) - 1] = par;
      end
      return w;
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: waits for acceptance, then pushes the expected item
   task automatic send(logic [30:0] w, bit odd, exp_t x);
      forever begin
         @(negedge clk);
         #1;
         in_valid = 1'b1;
         in_cw    = w;
         cfg_odd  = odd;
         if (in_ready) break;
      end
      sb.push_back(x);
      @(posedge clk);
      #0.5;
      check(out_valid === 1'b1, "R8", "valid one cycle after accept", 64'(out_valid), 64'd1);
      in_valid = 1'b0;
   endtask

   // output side: pseudo-random ready, hold and stall checks, scoreboard pop
   logic [15:0] lfsr = 16'hACE1;
   bit          held = 1'b0;
   logic [31:0] held_word;
   always @(negedge clk) begin
      if (run_rdy) begin
         lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = (lfsr[1:0] != 2'b00) || (lfsr[7:4] == 4'hF);
      end
      #0.5;
      if (!rst) begin
         if (held) begin
            check(out_valid === 1'b1 && {out_mismatch, out_err, out_pos, out_data} === held_word,
                  "R9", "stalled word held", 64'({out_valid, out_mismatch, out_err, out_pos, out_data}),
                  64'({1'b1, held_word}));
         end
         held = 1'b0;
         if (out_valid && !out_ready) begin
            check(in_ready === 1'b0, "R10", "in_ready low while stalled", 64'(in_ready), 64'd0);
            held      = 1'b1;
            held_word = {out_mismatch, out_err, out_pos, out_data};
         end
         if (out_valid && out_ready) begin
            if (sb.size() == 0) begin
               check(1'b0, "R10", "output with nothing sent", 64'(out_data), 64'd0);
            end else begin
               exp_t x;
               x = sb.pop_front();
               check({out_mismatch, out_err, out_pos, out_data} === {x.mm, x.e, x.p, x.d},
                     x.tag, "decoded word {mm,err,pos,data}",
                     64'({out_mismatch, out_err, out_pos, out_data}), 64'({x.mm, x.e, x.p, x.d}));
            end
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog: actual run incomplete expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [24:0] pats [6];
      logic [31:0] rs;
      pats[0] = 25'h0000000;
      pats[1] = 25'h1FFFFFF;
      pats[2] = 25'h1555555;
      pats[3] = 25'h0AAAAAA;
      pats[4] = 25'h0000001;
      pats[5] = 25'h1000000;

      repeat (3) @(posedge clk);
      #0.5;
      check(out_valid === 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
      @(negedge clk);
      rst = 1'b0;
      #0.5;
      check(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
      check(out_valid === 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      // idle with ready high: nothing must come out
      out_ready = 1'b1;
      repeat (4) @(negedge clk);
      #0.5;
      check(out_valid === 1'b0, "R10", "idle produces nothing", 64'(out_valid), 64'd0);
      run_rdy = 1'b1;

      rs = 32'h1234_5678;
      for (int pi = 0; pi < 8; pi++) begin
         logic [24:0] d;
         if (pi < 6) d = pats[pi];
         else begin
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            d  = rs[24:0];
         end
         for (int odd = 0; odd < 2; odd++) begin
            for (int f = 0; f < 32; f++) begin
               exp_t x;
               logic [30:0] w;
               w = encode(d, bit'(odd), bit'(odd));
               if (f != 0) w[f-1] = ~w[f-1];
               x.d  = d;
               x.e  = (f != 0);
               x.p  = 5'(f);
               x.mm = 1'b0;
               if (f == 0)                x.tag = (odd != 0) ? "R3" : "R2";
               else if (f == 3)           x.tag = "R6";
               else if (reserved(f))      x.tag = "R5";
               else                       x.tag = "R4";
               send(w, bit'(odd), x);
            end
            // sense bit opposite to the configured sense, clean and with one data flip
            for (int f = 0; f < 2; f++) begin
               exp_t x;
               logic [30:0] w;
               w = encode(d, bit'(odd), bit'(!odd));
               if (f != 0) w[9] = ~w[9];
               x.d   = d;
               x.e   = (f != 0);
               x.p   = (f != 0) ? 5'd10 : 5'd0;
               x.mm  = 1'b1;
               x.tag = "R7";
               send(w, bit'(odd), x);
            end
         end
      end

      while (sb.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule